// File: doc/BRIEF.md
# Banked Port I/O Decoder

This block sits between a processor core that can name only eight input ports and eight output ports and a larger set of peripheral registers. A software-written bank register holds a 3-bit bank number; each port transaction carries a 3-bit port number. Together they form a 6-bit register selector. A build-time map marks every bank/port pair as either on-chip or off-chip. On-chip transactions go to an internal register file through a simple strobe interface. Off-chip transactions drive an external address, active-low read and write strobes and an output enable for the shared 16-bit data bus.

Every transaction takes two cycles. The core raises a one-cycle request while the block is idle. The bank number is captured together with the request, so a later bank write does not change a transaction that is already running. Read results appear on a registered output, together with a one-cycle valid pulse.

Top module: `pio_bank_decoder`

## Requirements
- R1: After reset, the bank register reads 0x0000. Both external strobes are high, the bus output enable is low, the external address is all ones (0xFFF), busy is low, the read-valid pulse is low and the read data is 0x0000.
- R2: A write to the bank register stores bits 2..0 of the written value and forces bits 15..3 to zero. The stored value can be read back on `bsel_q` in the cycle after the write.
- R3: An off-chip output transaction drives `ext_we_n` low for exactly its first cycle and presents the write data on `ext_d_out` in that cycle. `ext_we_n` is high in the second cycle.
- R4: An off-chip input transaction holds `ext_ren_n` low for both of its cycles. `ext_d_in` is sampled at the end of the second cycle and appears on `io_rdata`, with `io_rdata_valid` high for the one following cycle.
- R5: An on-chip transaction never lowers either external strobe and never enables the bus. An on-chip output pulses `int_we` in the first cycle, with `int_addr` = {bank, port} (bank in bits 5..3) and `int_wdata` = the write data.
- R6: An on-chip input asserts `int_re` in the second cycle. The read result is `int_rdata` when `int_valid` is high and 0x0000 otherwise. It is reported on `io_rdata` in the same way as in R4.
- R7: The pair with index bank*8+port is routed off-chip when bit (bank*8+port) of `EXT_MAP` is set. With the default map, all of bank 0 and the pair bank 7/port 7 are off-chip, and every other pair is on-chip.
- R8: `ext_d_oe` is high only while `ext_we_n` is low. While a transaction is active, `ext_addr` bits 11..3 are all ones and bits 2..0 carry the port number. When idle, `ext_addr` is all ones.
- R9: `io_busy` is high for exactly the two cycles of a transaction. A request raised while busy is ignored. The bank used is the one held in the register in the cycle the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_req | input | 1 | Transaction request, accepted only when idle |
| io_wr | input | 1 | 1 = output (write) transaction, 0 = input (read) |
| io_port | input | 3 | Port number |
| io_wdata | input | 16 | Data for an output transaction |
| io_busy | output | 1 | Transaction in progress |
| io_rdata | output | 16 | Result of the last input transaction |
| io_rdata_valid | output | 1 | One-cycle pulse when a new read result is available |
| bsel_we | input | 1 | Bank register write strobe |
| bsel_wdata | input | 16 | Bank register write value |
| bsel_q | output | 16 | Bank register contents |
| int_addr | output | 6 | On-chip register selector {bank, port} |
| int_we | output | 1 | On-chip write pulse |
| int_re | output | 1 | On-chip read strobe |
| int_wdata | output | 16 | On-chip write data |
| int_rdata | input | 16 | On-chip read data |
| int_valid | input | 1 | On-chip register exists at `int_addr` |
| ext_addr | output | 12 | External address |
| ext_ren_n | output | 1 | External read strobe, active low |
| ext_we_n | output | 1 | External write strobe, active low |
| ext_d_oe | output | 1 | External data bus output enable |
| ext_d_out | output | 16 | External data bus outgoing value |
| ext_d_in | input | 16 | External data bus incoming value |

## Verification
The bench changes the bank register in the same cycle as a request and again in the middle of a transaction. A design that reads the bank live instead of capturing it would send the second cycle to the wrong register. It holds the request high across a whole transaction; a design that accepts requests while busy would start a phantom third cycle or a second write. It reads one mapped and one unmapped on-chip register, which exposes a design that passes stale data instead of zero, and it uses the lone off-chip pair in bank 7 to catch a swapped bank/port index into the routing map. Write strobe and bus enable are compared cycle by cycle, so a strobe that lasts two cycles or is lowered for on-chip targets is reported.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } pio_phase_e;
endpackage

// File: rtl/pio_bank_reg.sv
module pio_bank_reg #(
   parameter int BSEL_W = 16,
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BSEL_W-1:0] wdata,
   output logic [BSEL_W-1:0] q,
   output logic [BANK_W-1:0] bank
);
   logic [BSEL_W-1:0] masked;

   for (genvar g = 0; g < BSEL_W; g++) begin : g_bit
      if (g < BANK_W) begin : g_keep
         assign masked[g] = wdata[g];
      end else begin : g_zero
         assign masked[g] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= masked;
   end

   assign bank = q[BANK_W-1:0];
endmodule

// File: rtl/pio_route.sv
module pio_route #(
   parameter int BANK_W = 3,
   parameter int PORT_W = 3,
   parameter logic [(1<<(BANK_W+PORT_W))-1:0] EXT_MAP = '0
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [PORT_W-1:0] port,
   output logic              is_ext
);
   localparam int SEL_W = BANK_W + PORT_W;
   localparam int NPAIR = 1 << SEL_W;

   logic [SEL_W-1:0] sel;
   logic [NPAIR-1:0] hit;

   assign sel = {bank, port};

   for (genvar g = 0; g < NPAIR; g++) begin : g_pair
      assign hit[g] = (sel == SEL_W'(g)) && EXT_MAP[g];
   end

   assign is_ext = |hit;
endmodule

// File: rtl/pio_seq.sv
module pio_seq
   import pio_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int PORT_W = 3,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [PORT_W-1:0] port,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BANK_W-1:0] bank,
   input  logic              is_ext,
   output pio_phase_e        phase,
   output logic              lat_wr,
   output logic              lat_ext,
   output logic [BANK_W-1:0] lat_bank,
   output logic [PORT_W-1:0] lat_port,
   output logic [DATA_W-1:0] lat_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         lat_wr   <= 1'b0;
         lat_ext  <= 1'b0;
         lat_bank <= '0;
         lat_port <= '0;
         lat_data <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (req) begin
               phase    <= PH_ONE;
               lat_wr   <= wr;
               lat_ext  <= is_ext;
               lat_bank <= bank;
               lat_port <= port;
               lat_data <= wdata;
            end
            PH_ONE:  phase <= PH_TWO;
            PH_TWO:  phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pio_drive.sv
module pio_drive
   import pio_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int PORT_W = 3,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  pio_phase_e               phase,
   input  logic                     lat_wr,
   input  logic                     lat_ext,
   input  logic [BANK_W-1:0]        lat_bank,
   input  logic [PORT_W-1:0]        lat_port,
   input  logic [DATA_W-1:0]        lat_data,
   input  logic [DATA_W-1:0]        ext_d_in,
   input  logic [DATA_W-1:0]        int_rdata,
   input  logic                     int_valid,
   output logic [ADDR_W-1:0]        ext_addr,
   output logic                     ext_ren_n,
   output logic                     ext_we_n,
   output logic                     ext_d_oe,
   output logic [DATA_W-1:0]        ext_d_out,
   output logic [BANK_W+PORT_W-1:0] int_addr,
   output logic                     int_we,
   output logic                     int_re,
   output logic [DATA_W-1:0]        int_wdata,
   output logic [DATA_W-1:0]        io_rdata,
   output logic                     io_rdata_valid
);
   localparam int HI_W = ADDR_W - PORT_W;

   logic active, first, second, ext_wr_phase;

   assign active       = (phase != PH_IDLE);
   assign first        = (phase == PH_ONE);
   assign second       = (phase == PH_TWO);
   assign ext_wr_phase = first && lat_wr && lat_ext;

   assign ext_addr  = active ? {{HI_W{1'b1}}, lat_port} : '1;
   assign ext_we_n  = !ext_wr_phase;
   assign ext_d_oe  = ext_wr_phase;
   assign ext_ren_n = !(active && !lat_wr && lat_ext);
   assign ext_d_out = lat_data;

   assign int_addr  = {lat_bank, lat_port};
   assign int_we    = first && lat_wr && !lat_ext;
   assign int_re    = second && !lat_wr && !lat_ext;
   assign int_wdata = lat_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rdata       <= '0;
         io_rdata_valid <= 1'b0;
      end else if (second && !lat_wr) begin
         io_rdata       <= lat_ext ? ext_d_in : (int_valid ? int_rdata : '0);
         io_rdata_valid <= 1'b1;
      end else begin
         io_rdata_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pio_bank_decoder.sv
module pio_bank_decoder
   import pio_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BSEL_W = 16,
   parameter int BANK_W = 3,
   parameter int PORT_W = 3,
   parameter int ADDR_W = 12,
   parameter logic [(1<<(BANK_W+PORT_W))-1:0] EXT_MAP = 64'h8000_0000_0000_00FF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     io_req,
   input  logic                     io_wr,
   input  logic [PORT_W-1:0]        io_port,
   input  logic [DATA_W-1:0]        io_wdata,
   output logic                     io_busy,
   output logic [DATA_W-1:0]        io_rdata,
   output logic                     io_rdata_valid,
   input  logic                     bsel_we,
   input  logic [BSEL_W-1:0]        bsel_wdata,
   output logic [BSEL_W-1:0]        bsel_q,
   output logic [BANK_W+PORT_W-1:0] int_addr,
   output logic                     int_we,
   output logic                     int_re,
   output logic [DATA_W-1:0]        int_wdata,
   input  logic [DATA_W-1:0]        int_rdata,
   input  logic                     int_valid,
   output logic [ADDR_W-1:0]        ext_addr,
   output logic                     ext_ren_n,
   output logic                     ext_we_n,
   output logic                     ext_d_oe,
   output logic [DATA_W-1:0]        ext_d_out,
   input  logic [DATA_W-1:0]        ext_d_in
);
   localparam int SEL_W = BANK_W + PORT_W;

   if (SEL_W > 10) begin : g_bad_sel
      $error("bank and port fields too wide for the routing map");
   end
   if (ADDR_W <= PORT_W) begin : g_bad_addr
      $error("external address must be wider than the port field");
   end
   if (BSEL_W < BANK_W) begin : g_bad_bsel
      $error("bank register narrower than the bank field");
   end

   logic [BANK_W-1:0] cur_bank;
   logic              route_ext;
   pio_phase_e        phase;
   logic              lat_wr, lat_ext;
   logic [BANK_W-1:0] lat_bank;
   logic [PORT_W-1:0] lat_port;
   logic [DATA_W-1:0] lat_data;

   pio_bank_reg #(.BSEL_W(BSEL_W), .BANK_W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bsel_we), .wdata(bsel_wdata),
      .q(bsel_q), .bank(cur_bank)
   );

   pio_route #(.BANK_W(BANK_W), .PORT_W(PORT_W), .EXT_MAP(EXT_MAP)) u_route (
      .bank(cur_bank), .port(io_port), .is_ext(route_ext)
   );

   pio_seq #(.BANK_W(BANK_W), .PORT_W(PORT_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req(io_req), .wr(io_wr), .port(io_port),
      .wdata(io_wdata), .bank(cur_bank), .is_ext(route_ext), .phase(phase),
      .lat_wr(lat_wr), .lat_ext(lat_ext), .lat_bank(lat_bank),
      .lat_port(lat_port), .lat_data(lat_data)
   );

   pio_drive #(.BANK_W(BANK_W), .PORT_W(PORT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drive (
      .clk(clk), .rst_n(rst_n), .phase(phase), .lat_wr(lat_wr), .lat_ext(lat_ext),
      .lat_bank(lat_bank), .lat_port(lat_port), .lat_data(lat_data),
      .ext_d_in(ext_d_in), .int_rdata(int_rdata), .int_valid(int_valid),
      .ext_addr(ext_addr), .ext_ren_n(ext_ren_n), .ext_we_n(ext_we_n),
      .ext_d_oe(ext_d_oe), .ext_d_out(ext_d_out), .int_addr(int_addr),
      .int_we(int_we), .int_re(int_re), .int_wdata(int_wdata),
      .io_rdata(io_rdata), .io_rdata_valid(io_rdata_valid)
   );

   assign io_busy = (phase != PH_IDLE);
endmodule

// File: rtl/pio_bank_decoder_chk.sv
module pio_bank_decoder_chk #(
   parameter int BSEL_W = 16,
   parameter int BANK_W = 3,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_busy,
   input logic              io_rdata_valid,
   input logic [BSEL_W-1:0] bsel_q,
   input logic              int_we,
   input logic              int_re,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              ext_ren_n,
   input logic              ext_we_n,
   input logic              ext_d_oe
);
   // R1 / R8: idle bus state
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !io_busy |-> (ext_addr == {ADDR_W{1'b1}}) && ext_we_n && ext_ren_n && !ext_d_oe);

   // R2: upper bank register bits stay zero
   a_r2_bank_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bsel_q[BSEL_W-1:BANK_W] == '0);

   // R3: write strobe lasts one cycle
   a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_we_n |=> ext_we_n);

   // R4: read strobe spans two cycles
   a_r4_ren_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_ren_n) |=> !ext_ren_n);

   // R5: on-chip strobes exclude external strobes
   a_r5_int_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (int_we || int_re) |-> (ext_we_n && ext_ren_n && !ext_d_oe));

   // R6: valid pulse follows a read cycle
   a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      io_rdata_valid |-> $past(int_re || !ext_ren_n));

   // R8: bus enable only with write strobe
   a_r8_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n)
      ext_d_oe |-> !ext_we_n);

   // R9: busy lasts exactly two cycles
   a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_busy) |=> io_busy);
   a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      (io_busy && $past(io_busy)) |=> !io_busy);
endmodule

bind pio_bank_decoder pio_bank_decoder_chk #(
   .BSEL_W(BSEL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/pio_bank_decoder_bench.sv
module pio_bank_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0, io_wr = 1'b0;
   logic [2:0]  io_port = '0;
   logic [15:0] io_wdata = '0;
   logic        io_busy, io_rdata_valid;
   logic [15:0] io_rdata;
   logic        bsel_we = 1'b0;
   logic [15:0] bsel_wdata = '0;
   logic [15:0] bsel_q;
   logic [5:0]  int_addr;
   logic        int_we, int_re;
   logic [15:0] int_wdata, int_rdata;
   logic        int_valid;
   logic [11:0] ext_addr;
   logic        ext_ren_n, ext_we_n, ext_d_oe;
   logic [15:0] ext_d_out;
   logic [15:0] ext_d_in = 16'h0000;

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   // On-chip register stub: ports 0..3 of every bank exist.
   assign int_valid = (int_addr[2:0] < 3'd4);
   assign int_rdata = 16'hA000 | {10'd0, int_addr};

   pio_bank_decoder u_pio_bank_decoder (.*);

   // Behavioural reference model
   int          m_phase = 0;
   logic [15:0] m_bsel = '0, m_data = '0, m_rdata = '0;
   logic [2:0]  m_bank = '0, m_port = '0;
   logic        m_wr = 0, m_ext = 0, m_valid = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_bsel = '0; m_rdata = '0; m_valid = 0;
      end else begin
         int  np;
         logic nv;
         np = m_phase; nv = 0;
         if (m_phase == 2) begin
            np = 0;
            if (!m_wr) begin
               nv = 1;
               if (m_ext) m_rdata = ext_d_in;
               else if (m_port < 4) m_rdata = 16'hA000 | {10'd0, m_bank, m_port};
               else m_rdata = 16'h0000;
            end
         end else if (m_phase == 1) begin
            np = 2;
         end else if (io_req) begin
            np = 1;
            m_bank = m_bsel[2:0]; m_port = io_port; m_wr = io_wr; m_data = io_wdata;
            m_ext = (m_bsel[2:0] == 3'd0) || (m_bsel[2:0] == 3'd7 && io_port == 3'd7);
         end
         if (bsel_we) m_bsel = {13'd0, bsel_wdata[2:0]};
         m_phase = np; m_valid = nv;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n && !done) begin
      logic act_on, wr_ext, rd_ext;
      act_on = (m_phase != 0);
      wr_ext = (m_phase == 1) && m_wr && m_ext;
      rd_ext = act_on && !m_wr && m_ext;
      chk("R2 bank register", 32'(bsel_q), 32'(m_bsel));
      chk("R3 write strobe", 32'(ext_we_n), 32'(!wr_ext));
      if (wr_ext) chk("R3 write data", 32'(ext_d_out), 32'(m_data));
      chk("R4 read strobe", 32'(ext_ren_n), 32'(!rd_ext));
      chk("R4/R6 read data", 32'(io_rdata), 32'(m_rdata));
      chk("R4/R6 read valid", 32'(io_rdata_valid), 32'(m_valid));
      chk("R5 int write", 32'(int_we), 32'((m_phase == 1) && m_wr && !m_ext));
      chk("R6 int read", 32'(int_re), 32'((m_phase == 2) && !m_wr && !m_ext));
      if (int_we || int_re) chk("R5 int addr", 32'(int_addr), 32'({m_bank, m_port}));
      if (int_we) chk("R5 int wdata", 32'(int_wdata), 32'(m_data));
      if (m_phase == 1 && m_wr) chk("R7 write routing", 32'({!ext_we_n, int_we}), 32'({m_ext, !m_ext}));
      if (m_phase == 2 && !m_wr) chk("R7 read routing", 32'({!ext_ren_n, int_re}), 32'({m_ext, !m_ext}));
      chk("R8 bus enable", 32'(ext_d_oe), 32'(wr_ext));
      chk("R8 address", 32'(ext_addr), act_on ? 32'({9'h1FF, m_port}) : 32'hFFF);
      chk("R9 busy", 32'(io_busy), 32'(act_on));
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic step(); @(posedge clk); #2; endtask

   task automatic set_bank(logic [15:0] v);
      bsel_we = 1; bsel_wdata = v; step(); bsel_we = 0;
   endtask

   task automatic access(logic wr, logic [2:0] port, logic [15:0] d);
      io_req = 1; io_wr = wr; io_port = port; io_wdata = d;
      step(); io_req = 0;
      step(); step(); step();
   endtask

   initial begin
      repeat (6000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) step();
      #3;
      // R1: reset state
      chk("R1 bank reset", 32'(bsel_q), 32'h0);
      chk("R1 strobes", 32'({ext_we_n, ext_ren_n, ext_d_oe}), 32'b110);
      chk("R1 address", 32'(ext_addr), 32'hFFF);
      chk("R1 busy/valid/data", 32'({io_busy, io_rdata_valid, io_rdata}), 32'h0);
      @(negedge clk); #1 rst_n = 1;
      step();
      // bank 0: off-chip
      ext_d_in = 16'hBEEF;
      access(1, 3'd3, 16'h1234);
      access(0, 3'd6, 16'h0);
      // R2: masked bank write -> bank 5
      set_bank(16'hABCD);
      access(1, 3'd2, 16'h5555);
      access(0, 3'd1, 16'h0);
      access(0, 3'd6, 16'h0);
      // bank 7: one off-chip pair
      set_bank(16'h0007);
      ext_d_in = 16'h7E57;
      access(0, 3'd7, 16'h0);
      access(1, 3'd7, 16'hCAFE);
      access(0, 3'd6, 16'h0);
      access(1, 3'd0, 16'h0F0F);
      // R9: request held high while busy
      io_req = 1; io_wr = 1; io_port = 3'd5; io_wdata = 16'h9999;
      step(); step(); step(); io_req = 0;
      step(); step();
      // R9: bank write in the request cycle, and mid-transaction
      io_req = 1; io_wr = 0; io_port = 3'd2; bsel_we = 1; bsel_wdata = 16'h0000;
      step(); io_req = 0; bsel_we = 0;
      step(); step(); step();
      io_req = 1; io_wr = 1; io_port = 3'd4; io_wdata = 16'h4444;
      step(); io_req = 0; bsel_we = 1; bsel_wdata = 16'hFFF3;
      step(); bsel_we = 0;
      step(); step();
      // back-to-back transactions
      ext_d_in = 16'h0A0A;
      io_req = 1; io_wr = 0; io_port = 3'd0;
      step(); io_req = 0; step(); io_req = 1; io_port = 3'd3;
      step(); io_req = 0; step(); step(); step();
      finish_run();
   end
endmodule